// File: doc/BRIEF.md
# Mode-Banked Processor Register File

This block holds the integer registers and status words of a 32-bit processor core that runs in seven privilege modes. Sixteen logical register numbers are visible at any time, but which storage cell sits behind each number depends on the current mode. The interrupt-fast mode replaces r8 to r14 with private copies. The four other exception modes each replace only r13 and r14. User and system mode share one set. r15 is the program counter and is the same cell in every mode. Two combinational read ports and one write port are addressed by a 4-bit logical number. The mode that selects the bank comes from the live status word.

The status word and one saved copy per exception mode live here as well. The block has three ways to change mode or state. A direct status write can move to any mode. An exception entry moves to the target exception mode and, in one clock edge, saves the old status word, the return address and the new program counter. A branch-exchange changes only the instruction-state bit and the program counter. The modes are user 10000, fast interrupt 10001, normal interrupt 10010, supervisor 10011, abort 10111, undefined 11011 and system 11111. The transitions are: reset, which goes to supervisor; status write, which goes to any mode; exception entry, which goes to one of the five exception modes; and branch-exchange, which keeps the mode.

Top module: `banked_regfile`

## Requirements
- R1: After reset the status word is 0x000000D3 (supervisor mode, I=1, F=1, T=0, flags zero), the program counter is 0, and every register and saved status word reads 0.
- R2: Read ports return, with no clock delay, the register selected by the logical number in the current mode. Logical 15 returns the program counter. r0 to r7 and r15 are one cell in every mode.
- R3: In fast-interrupt mode (10001), r8 to r14 are private cells, separate from the user cells.
- R4: In normal-interrupt (10010), supervisor (10011), abort (10111) and undefined (11011) mode, only r13 and r14 are private. r8 to r12 are the user cells.
- R5: User (10000) and system (11111) mode see the same cells for all sixteen numbers.
- R6: A read of the cell being written in the same cycle returns the old value. The new value is visible from the next cycle.
- R7: A status write stores all 32 bits. The bank follows the new mode field from the next cycle. A mode field that is not one of the seven encodings selects the user bank and has no saved status word.
- R8: The saved-status port reads and writes the current mode's saved word. In user, system or an unrecognised mode it reads 0, and writes are ignored.
- R9: Exception entry, with kind 0 fast interrupt, 1 normal interrupt, 2 supervisor, 3 abort and 4 to 7 undefined, does two things in one edge. It copies the program counter into r14 of the target mode. It loads the program counter with VEC_BASE plus 0x1C, 0x18, 0x08, 0x10 or 0x04 respectively.
- R10: On the same edge the old status word goes to the target mode's saved word. The mode field becomes the target, I (bit 7) is set, T (bit 5) is cleared, and F (bit 6) is set only for fast-interrupt entry and otherwise kept. Flags (bits 31:28) are kept.
- R11: Branch-exchange reads Rm in the current mode. It sets T (bit 5) from Rm[0] and loads the program counter with Rm with bit 0 cleared. All other status bits are kept.
- R12: Exception entry overrides branch-exchange, status write and saved-status write in the same cycle, and those three are then ignored. A status write is ignored during a branch-exchange. Where the general write port targets a cell that exception entry or branch-exchange also writes, the latter wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_a_idx | input | 4 | Logical number for read port A |
| rd_a_data | output | DATA_W | Read port A data |
| rd_b_idx | input | 4 | Logical number for read port B |
| rd_b_data | output | DATA_W | Read port B data |
| wr_en | input | 1 | General write enable |
| wr_idx | input | 4 | Logical number for the write |
| wr_data | input | DATA_W | Write data |
| cpsr_we | input | 1 | Direct status word write |
| cpsr_wdata | input | 32 | New status word |
| cpsr_out | output | 32 | Current status word |
| spsr_we | input | 1 | Saved-status write for current mode |
| spsr_wdata | input | 32 | Saved-status write data |
| spsr_rd | output | 32 | Current mode's saved status word |
| bx_req | input | 1 | Branch-exchange request |
| bx_idx | input | 4 | Logical number of Rm |
| exc_req | input | 1 | Exception entry request |
| exc_kind | input | 3 | Exception kind |
| pc_out | output | DATA_W | Program counter |

## Verification
The collision that matters is exception entry landing in the same cycle as other state changes: a branch-exchange, a status write, a saved-status write and a general write to the program counter or to the target mode's r14. Directed cycles drive all of these together: first from undefined into normal-interrupt mode, then from normal-interrupt mode into itself, so that the general write and the return-address save hit one cell. The bench then reads back the winning values, and the untouched saved word of the old mode, through the ports. The random phase raises each request independently, so these overlaps recur, and a bench model that applies the priority order judges every cycle.

// File: rtl/bank_pkg.sv
package bank_pkg;
    localparam int          SR_W     = 32;
    localparam int          NPHYS    = 32;
    localparam int          PHYS_W   = $clog2(NPHYS);
    localparam logic [PHYS_W-1:0] PC_SLOT = PHYS_W'(NPHYS - 1);
    localparam int          NSAVED   = 5;
    localparam logic [2:0]  NO_SLOT  = 3'd7;
    localparam int          SR_T     = 5;
    localparam int          SR_F     = 6;
    localparam int          SR_I     = 7;

    typedef enum logic [4:0] {
        MODE_USR = 5'b10000,
        MODE_FIQ = 5'b10001,
        MODE_IRQ = 5'b10010,
        MODE_SVC = 5'b10011,
        MODE_ABT = 5'b10111,
        MODE_UND = 5'b11011,
        MODE_SYS = 5'b11111
    } mode_e;

    function automatic logic [4:0] exc_target(input logic [2:0] kind);
        logic [4:0] m;
        unique case (kind)
            3'd0:    m = MODE_FIQ;
            3'd1:    m = MODE_IRQ;
            3'd2:    m = MODE_SVC;
            3'd3:    m = MODE_ABT;
            default: m = MODE_UND;
        endcase
        return m;
    endfunction

    function automatic logic [7:0] exc_offset(input logic [2:0] kind);
        logic [7:0] o;
        unique case (kind)
            3'd0:    o = 8'h1C;
            3'd1:    o = 8'h18;
            3'd2:    o = 8'h08;
            3'd3:    o = 8'h10;
            default: o = 8'h04;
        endcase
        return o;
    endfunction

    function automatic logic [2:0] spsr_slot(input logic [4:0] mode);
        logic [2:0] s;
        unique case (mode)
            MODE_FIQ: s = 3'd0;
            MODE_IRQ: s = 3'd1;
            MODE_SVC: s = 3'd2;
            MODE_ABT: s = 3'd3;
            MODE_UND: s = 3'd4;
            default:  s = NO_SLOT;
        endcase
        return s;
    endfunction
endpackage

// File: rtl/bank_index.sv
module bank_index
    import bank_pkg::*;
(
    input  logic [4:0]        mode,
    input  logic [3:0]        idx,
    output logic [PHYS_W-1:0] phys
);
    logic [PHYS_W-1:0] base;
    logic              hi_pair;
    logic              hi_seven;

    assign base     = PHYS_W'(idx);
    assign hi_pair  = (idx == 4'd13) || (idx == 4'd14);
    assign hi_seven = (idx >= 4'd8) && (idx <= 4'd14);

    always_comb begin
        phys = (idx == 4'd15) ? PC_SLOT : base;
        unique case (mode)
            MODE_FIQ: if (hi_seven) phys = base + PHYS_W'(8);
            MODE_IRQ: if (hi_pair)  phys = base + PHYS_W'(10);
            MODE_SVC: if (hi_pair)  phys = base + PHYS_W'(12);
            MODE_ABT: if (hi_pair)  phys = base + PHYS_W'(14);
            MODE_UND: if (hi_pair)  phys = base + PHYS_W'(16);
            default:  ;
        endcase
    end
endmodule

// File: rtl/status_bank.sv
module status_bank
    import bank_pkg::*;
#(
    parameter logic [SR_W-1:0] RESET_SR = 32'h0000_00D3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            exc_req,
    input  logic [4:0]      exc_mode,
    input  logic            bx_req,
    input  logic            bx_t,
    input  logic            cpsr_we,
    input  logic [SR_W-1:0] cpsr_wdata,
    input  logic            spsr_we,
    input  logic [SR_W-1:0] spsr_wdata,
    output logic [SR_W-1:0] cpsr,
    output logic [SR_W-1:0] spsr_rd
);
    logic [SR_W-1:0] cpsr_q;
    logic [SR_W-1:0] cpsr_d;
    logic [SR_W-1:0] spsr_q [NSAVED];
    logic [2:0]      cur_slot;
    logic [2:0]      tgt_slot;

    assign cur_slot = spsr_slot(cpsr_q[4:0]);
    assign tgt_slot = spsr_slot(exc_mode);
    assign cpsr     = cpsr_q;

    always_comb begin
        cpsr_d = cpsr_q;
        if (exc_req) begin
            cpsr_d[4:0]  = exc_mode;
            cpsr_d[SR_T] = 1'b0;
            cpsr_d[SR_I] = 1'b1;
            if (exc_mode == MODE_FIQ) cpsr_d[SR_F] = 1'b1;
        end else if (bx_req) begin
            cpsr_d[SR_T] = bx_t;
        end else if (cpsr_we) begin
            cpsr_d = cpsr_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cpsr_q <= RESET_SR;
        else        cpsr_q <= cpsr_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < NSAVED; s++) spsr_q[s] <= '0;
        end else begin
            for (int s = 0; s < NSAVED; s++) begin
                if (exc_req && tgt_slot == 3'(s))
                    spsr_q[s] <= cpsr_q;
                else if (spsr_we && !exc_req && cur_slot == 3'(s))
                    spsr_q[s] <= spsr_wdata;
            end
        end
    end

    always_comb begin
        spsr_rd = '0;
        for (int s = 0; s < NSAVED; s++)
            if (cur_slot == 3'(s)) spsr_rd = spsr_q[s];
    end

    // R10
    exc_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_req |=> cpsr_q[4:0] == $past(exc_mode) && cpsr_q[SR_I] && !cpsr_q[SR_T]);
    // R10
    exc_save_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_req |=> spsr_rd == $past(cpsr_q));
    // R10
    exc_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_req && exc_mode != MODE_FIQ) |=>
            cpsr_q[SR_F] == $past(cpsr_q[SR_F]) && cpsr_q[31:28] == $past(cpsr_q[31:28]));
    // R11
    bx_tbit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bx_req && !exc_req) |=> cpsr_q[SR_T] == $past(bx_t) && cpsr_q[4:0] == $past(cpsr_q[4:0]));
endmodule

// File: rtl/gpr_store.sv
module gpr_store
    import bank_pkg::*;
#(
    parameter int                DATA_W   = 32,
    parameter logic [DATA_W-1:0] RESET_PC = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [PHYS_W-1:0] wr_phys,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              exc_req,
    input  logic [PHYS_W-1:0] lr_phys,
    input  logic [DATA_W-1:0] vec_addr,
    input  logic              bx_req,
    input  logic [DATA_W-1:0] bx_pc,
    input  logic [PHYS_W-1:0] rd_a_phys,
    input  logic [PHYS_W-1:0] rd_b_phys,
    input  logic [PHYS_W-1:0] bx_phys,
    output logic [DATA_W-1:0] rd_a_data,
    output logic [DATA_W-1:0] rd_b_data,
    output logic [DATA_W-1:0] bx_val,
    output logic [DATA_W-1:0] pc
);
    logic [DATA_W-1:0] regs_q [NPHYS];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NPHYS; i++)
                regs_q[i] <= (PHYS_W'(i) == PC_SLOT) ? RESET_PC : '0;
        end else begin
            if (wr_en)   regs_q[wr_phys] <= wr_data;
            if (bx_req)  regs_q[PC_SLOT] <= bx_pc;
            if (exc_req) begin
                regs_q[lr_phys] <= regs_q[PC_SLOT];
                regs_q[PC_SLOT] <= vec_addr;
            end
        end
    end

    assign rd_a_data = regs_q[rd_a_phys];
    assign rd_b_data = regs_q[rd_b_phys];
    assign bx_val    = regs_q[bx_phys];
    assign pc        = regs_q[PC_SLOT];

    // R9
    exc_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_req |=> pc == $past(vec_addr));
    // R9
    exc_lr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_req |=> regs_q[$past(lr_phys)] == $past(regs_q[PC_SLOT]));
    // R11
    bx_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bx_req && !exc_req) |=> pc == $past(bx_pc));
    // R6
    wr_land_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_phys != PC_SLOT && !(exc_req && wr_phys == lr_phys))
            |=> regs_q[$past(wr_phys)] == $past(wr_data));
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
    import bank_pkg::*;
#(
    parameter int                DATA_W   = 32,
    parameter logic [DATA_W-1:0] VEC_BASE = '0,
    parameter logic [DATA_W-1:0] RESET_PC = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        rd_a_idx,
    output logic [DATA_W-1:0] rd_a_data,
    input  logic [3:0]        rd_b_idx,
    output logic [DATA_W-1:0] rd_b_data,
    input  logic              wr_en,
    input  logic [3:0]        wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              cpsr_we,
    input  logic [SR_W-1:0]   cpsr_wdata,
    output logic [SR_W-1:0]   cpsr_out,
    input  logic              spsr_we,
    input  logic [SR_W-1:0]   spsr_wdata,
    output logic [SR_W-1:0]   spsr_rd,
    input  logic              bx_req,
    input  logic [3:0]        bx_idx,
    input  logic              exc_req,
    input  logic [2:0]        exc_kind,
    output logic [DATA_W-1:0] pc_out
);
    localparam int NMAP = 5;

    logic [4:0]        cur_mode;
    logic [4:0]        tgt_mode;
    logic [3:0]        map_idx  [NMAP];
    logic [4:0]        map_mode [NMAP];
    logic [PHYS_W-1:0] map_phys [NMAP];
    logic [DATA_W-1:0] bx_val;
    logic [DATA_W-1:0] bx_pc;
    logic [DATA_W-1:0] vec_addr;
    logic              bx_go;

    assign cur_mode = cpsr_out[4:0];
    assign tgt_mode = exc_target(exc_kind);
    assign bx_go    = bx_req && !exc_req;
    assign bx_pc    = {bx_val[DATA_W-1:1], 1'b0};
    assign vec_addr = VEC_BASE + DATA_W'(exc_offset(exc_kind));

    assign map_idx[0] = rd_a_idx;  assign map_mode[0] = cur_mode;
    assign map_idx[1] = rd_b_idx;  assign map_mode[1] = cur_mode;
    assign map_idx[2] = wr_idx;    assign map_mode[2] = cur_mode;
    assign map_idx[3] = bx_idx;    assign map_mode[3] = cur_mode;
    assign map_idx[4] = 4'd14;     assign map_mode[4] = tgt_mode;

    for (genvar g = 0; g < NMAP; g++) begin : g_map
        bank_index u_map (
            .mode (map_mode[g]),
            .idx  (map_idx[g]),
            .phys (map_phys[g])
        );
    end

    status_bank u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .exc_req    (exc_req),
        .exc_mode   (tgt_mode),
        .bx_req     (bx_go),
        .bx_t       (bx_val[0]),
        .cpsr_we    (cpsr_we),
        .cpsr_wdata (cpsr_wdata),
        .spsr_we    (spsr_we),
        .spsr_wdata (spsr_wdata),
        .cpsr       (cpsr_out),
        .spsr_rd    (spsr_rd)
    );

    gpr_store #(.DATA_W(DATA_W), .RESET_PC(RESET_PC)) u_gpr (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_phys   (map_phys[2]),
        .wr_data   (wr_data),
        .exc_req   (exc_req),
        .lr_phys   (map_phys[4]),
        .vec_addr  (vec_addr),
        .bx_req    (bx_go),
        .bx_pc     (bx_pc),
        .rd_a_phys (map_phys[0]),
        .rd_b_phys (map_phys[1]),
        .bx_phys   (map_phys[3]),
        .rd_a_data (rd_a_data),
        .rd_b_data (rd_b_data),
        .bx_val    (bx_val),
        .pc        (pc_out)
    );

    // R12
    exc_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_req && (cpsr_we || bx_req)) |=> cpsr_out[4:0] == exc_target($past(exc_kind)));
endmodule

// File: tb/banked_regfile_tb.sv
`timescale 1ns/1ps
module banked_regfile_tb;
    localparam real CLK_T = 4.0;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [3:0]  rd_a_idx, rd_b_idx, wr_idx, bx_idx;
    logic [31:0] rd_a_data, rd_b_data, wr_data, cpsr_wdata, cpsr_out;
    logic [31:0] spsr_wdata, spsr_rd, pc_out;
    logic        wr_en, cpsr_we, spsr_we, bx_req, exc_req;
    logic [2:0]  exc_kind;

    int n_chk = 0;
    int n_err = 0;

    logic [31:0] mg [32];
    logic [31:0] mc;
    logic [31:0] ms [5];

    always #(CLK_T/2) clk = ~clk;

    banked_regfile u_dut (
        .clk(clk), .rst_n(rst_n),
        .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
        .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .cpsr_we(cpsr_we), .cpsr_wdata(cpsr_wdata), .cpsr_out(cpsr_out),
        .spsr_we(spsr_we), .spsr_wdata(spsr_wdata), .spsr_rd(spsr_rd),
        .bx_req(bx_req), .bx_idx(bx_idx),
        .exc_req(exc_req), .exc_kind(exc_kind), .pc_out(pc_out)
    );

    function automatic int bphys(logic [4:0] m, logic [3:0] i);
        if (i == 4'd15) return 31;
        case (m)
            5'b10001: if (i >= 4'd8)  return int'(i) + 8;
            5'b10010: if (i >= 4'd13) return int'(i) + 10;
            5'b10011: if (i >= 4'd13) return int'(i) + 12;
            5'b10111: if (i >= 4'd13) return int'(i) + 14;
            5'b11011: if (i >= 4'd13) return int'(i) + 16;
            default: ;
        endcase
        return int'(i);
    endfunction

    function automatic int bslot(logic [4:0] m);
        case (m)
            5'b10001: return 0;
            5'b10010: return 1;
            5'b10011: return 2;
            5'b10111: return 3;
            5'b11011: return 4;
            default:  return -1;
        endcase
    endfunction

    function automatic logic [4:0] btgt(logic [2:0] k);
        case (k)
            3'd0: return 5'b10001;
            3'd1: return 5'b10010;
            3'd2: return 5'b10011;
            3'd3: return 5'b10111;
            default: return 5'b11011;
        endcase
    endfunction

    function automatic logic [31:0] boff(logic [2:0] k);
        case (k)
            3'd0: return 32'h1C;
            3'd1: return 32'h18;
            3'd2: return 32'h08;
            3'd3: return 32'h10;
            default: return 32'h04;
        endcase
    endfunction

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic compare_all(input string tag);
        logic [4:0] m;
        int s;
        m = mc[4:0];
        s = bslot(m);
        chk(tag, "rd_a", rd_a_data, mg[bphys(m, rd_a_idx)]);
        chk(tag, "rd_b", rd_b_data, mg[bphys(m, rd_b_idx)]);
        chk(tag, "cpsr", cpsr_out, mc);
        chk(tag, "pc", pc_out, mg[31]);
        chk(tag, "spsr", spsr_rd, (s < 0) ? 32'h0 : ms[s]);
    endtask

    task automatic model_step();
        logic [31:0] ng [32];
        logic [31:0] ns [5];
        logic [31:0] nc, rm;
        logic [4:0]  m, tm;
        int s;
        ng = mg; ns = ms; nc = mc;
        m = mc[4:0];
        s = bslot(m);
        if (wr_en) ng[bphys(m, wr_idx)] = wr_data;
        if (spsr_we && !exc_req && s >= 0) ns[s] = spsr_wdata;
        if (cpsr_we && !exc_req && !bx_req) nc = cpsr_wdata;
        if (bx_req && !exc_req) begin
            rm = mg[bphys(m, bx_idx)];
            ng[31] = {rm[31:1], 1'b0};
            nc = mc;
            nc[5] = rm[0];
        end
        if (exc_req) begin
            tm = btgt(exc_kind);
            ng[bphys(tm, 4'd14)] = mg[31];
            ng[31] = boff(exc_kind);
            ns[bslot(tm)] = mc;
            nc = mc;
            nc[4:0] = tm;
            nc[7] = 1'b1;
            nc[5] = 1'b0;
            if (exc_kind == 3'd0) nc[6] = 1'b1;
        end
        mg = ng; ms = ns; mc = nc;
    endtask

    task automatic idle();
        wr_en = 0; cpsr_we = 0; spsr_we = 0; bx_req = 0; exc_req = 0;
    endtask

    task automatic tick(input string tag);
        #1;
        compare_all(tag);
        model_step();
        @(posedge clk);
        @(negedge clk);
        idle();
    endtask

    task automatic set_sr(input logic [31:0] v, input string tag);
        cpsr_we = 1; cpsr_wdata = v; tick(tag);
    endtask

    task automatic wr(input logic [3:0] i, input logic [31:0] v, input string tag);
        wr_en = 1; wr_idx = i; wr_data = v; tick(tag);
    endtask

    task automatic look(input logic [3:0] i, input logic [31:0] exp, input string tag);
        rd_a_idx = i; #0.5;
        chk(tag, "look", rd_a_data, exp);
        tick(tag);
    endtask

    initial begin
        #(CLK_T * 200000);
        n_err++;
        $display("FAIL R2 watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < 32; i++) mg[i] = '0;
        for (int i = 0; i < 5; i++) ms[i] = '0;
        mc = 32'h0000_00D3;
        rst_n = 0; idle();
        rd_a_idx = 0; rd_b_idx = 0; wr_idx = 0; bx_idx = 0; exc_kind = 0;
        wr_data = 0; cpsr_wdata = 0; spsr_wdata = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        #0.5;
        // R1 reset state
        chk("R1", "cpsr", cpsr_out, 32'h0000_00D3);
        chk("R1", "pc", pc_out, 32'h0);
        chk("R1", "spsr", spsr_rd, 32'h0);
        chk("R1", "r0", rd_a_data, 32'h0);
        tick("R1");

        // R5 / R2: user and system share cells
        set_sr(32'h10, "R7");
        wr(4'd13, 32'hAAAA, "R5");
        wr(4'd0, 32'h11, "R2");
        set_sr(32'h1F, "R5");
        look(4'd13, 32'hAAAA, "R5");
        look(4'd0, 32'h11, "R2");

        // R3: fast-interrupt private r8-r14
        set_sr(32'hD1, "R3");
        wr(4'd8, 32'hF8, "R3");
        wr(4'd14, 32'hFE, "R3");
        look(4'd8, 32'hF8, "R3");
        look(4'd0, 32'h11, "R3");
        look(4'd13, 32'h0, "R3");
        set_sr(32'h10, "R3");
        look(4'd8, 32'h0, "R3");
        look(4'd14, 32'h0, "R3");

        // R4: only r13/r14 private
        set_sr(32'hD3, "R4");
        wr(4'd13, 32'h5D, "R4");
        wr(4'd8, 32'h88, "R4");
        set_sr(32'hD2, "R4");
        look(4'd13, 32'h0, "R4");
        look(4'd8, 32'h88, "R4");
        set_sr(32'hD3, "R4");
        look(4'd13, 32'h5D, "R4");

        // R6: read during write returns old
        wr_en = 1; wr_idx = 4'd2; wr_data = 32'h22; rd_a_idx = 4'd2; #0.5;
        chk("R6", "old", rd_a_data, 32'h0);
        tick("R6");
        look(4'd2, 32'h22, "R6");

        // R7: unknown mode uses user bank
        set_sr(32'h15, "R7");
        #0.5; chk("R7", "cpsr", cpsr_out, 32'h15);
        tick("R7");
        look(4'd13, 32'hAAAA, "R7");

        // R8: saved status in user/system/unknown
        spsr_we = 1; spsr_wdata = 32'hBEEF; tick("R8");
        #0.5; chk("R8", "spsr_unknown", spsr_rd, 32'h0); tick("R8");
        set_sr(32'h10, "R8");
        spsr_we = 1; spsr_wdata = 32'hBEEF; tick("R8");
        #0.5; chk("R8", "spsr_usr", spsr_rd, 32'h0); tick("R8");
        set_sr(32'hD3, "R8");
        spsr_we = 1; spsr_wdata = 32'h1234; tick("R8");
        #0.5; chk("R8", "spsr_svc", spsr_rd, 32'h1234); tick("R8");

        // R9 / R10: exception entries
        set_sr(32'hF000_0010, "R10");
        wr(4'd15, 32'h100, "R9");
        exc_req = 1; exc_kind = 3'd0; tick("R9");
        rd_a_idx = 4'd14; #0.5;
        chk("R9", "pc", pc_out, 32'h1C);
        chk("R9", "lr", rd_a_data, 32'h100);
        chk("R10", "cpsr", cpsr_out, 32'hF000_00D1);
        chk("R10", "spsr", spsr_rd, 32'hF000_0010);
        tick("R10");
        exc_req = 1; exc_kind = 3'd6; tick("R9");
        rd_a_idx = 4'd14; #0.5;
        chk("R9", "pc", pc_out, 32'h04);
        chk("R9", "lr", rd_a_data, 32'h1C);
        chk("R10", "cpsr", cpsr_out, 32'hF000_00DB);
        chk("R10", "spsr", spsr_rd, 32'hF000_00D1);
        tick("R10");

        // R11: branch-exchange
        wr(4'd3, 32'h201, "R11");
        bx_req = 1; bx_idx = 4'd3; tick("R11");
        #0.5;
        chk("R11", "pc", pc_out, 32'h200);
        chk("R11", "cpsr", cpsr_out, 32'hF000_00FB);
        tick("R11");
        wr(4'd4, 32'h300, "R11");
        bx_req = 1; bx_idx = 4'd4; tick("R11");
        #0.5;
        chk("R11", "pc", pc_out, 32'h300);
        chk("R11", "cpsr", cpsr_out, 32'hF000_00DB);
        tick("R11");

        // R12: everything at once, exception wins
        exc_req = 1; exc_kind = 3'd1; bx_req = 1; bx_idx = 4'd3;
        cpsr_we = 1; cpsr_wdata = 32'h10; spsr_we = 1; spsr_wdata = 32'h5555;
        wr_en = 1; wr_idx = 4'd15; wr_data = 32'h999;
        tick("R12");
        rd_a_idx = 4'd14; #0.5;
        chk("R12", "pc", pc_out, 32'h18);
        chk("R12", "cpsr", cpsr_out, 32'hF000_00D2);
        chk("R12", "spsr", spsr_rd, 32'hF000_00DB);
        chk("R12", "lr", rd_a_data, 32'h300);
        tick("R12");
        exc_req = 1; exc_kind = 3'd1; wr_en = 1; wr_idx = 4'd14; wr_data = 32'hABC;
        tick("R12");
        look(4'd14, 32'h18, "R12");
        set_sr(32'hDB, "R12");
        #0.5; chk("R12", "und_spsr_kept", spsr_rd, 32'hF000_00D1); tick("R12");

        // random phase
        for (int n = 0; n < 4000; n++) begin
            logic [4:0] modes [8];
            logic [31:0] r;
            modes = '{5'b10000, 5'b10001, 5'b10010, 5'b10011, 5'b10111, 5'b11011, 5'b11111, 5'b00101};
            rd_a_idx = 4'($urandom); rd_b_idx = 4'($urandom);
            wr_en = ($urandom % 2) == 0; wr_idx = 4'($urandom); wr_data = $urandom;
            cpsr_we = ($urandom % 10) == 0;
            r = $urandom;
            cpsr_wdata = {r[31:5], modes[$urandom % 8]};
            spsr_we = ($urandom % 7) == 0; spsr_wdata = $urandom;
            bx_req = ($urandom % 16) == 0; bx_idx = 4'($urandom);
            exc_req = ($urandom % 20) == 0; exc_kind = 3'($urandom);
            tick("R2");
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule